// File: doc/BRIEF.md
# Request Opcode and Attribute Qualifier

This block sits in front of a bank of event counters. Each cycle it looks at one request descriptor and decides whether the current event should be counted. The event is either an insertion into a request queue or an occupancy sample of that queue. The descriptor carries:
- a valid bit
- a queue identifier
- an opcode
- a flag that says whether the target is local (set) or remote (clear)
- a near-memory-cacheable flag
- a non-coherent flag
- an isochronous flag

Software programs the qualifier with:
- two opcode compare values, which both work at the same time
- the queue that requests must come from
- six single-bit attribute enables

The block produces one registered match bit. The counter in front of it adds that bit to its count. For any other kind of event, the qualifier does not filter: its output is forced to pass. Opcode value zero in a compare register switches that comparator off. When both comparators are zero, opcode filtering is off entirely.

Top module: `req_qual`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `match_o` is 0.
- R2: `match_o` is a register. A change on the inputs sampled at a rising clock edge appears on `match_o` just after that edge, and the value is held until the next edge.
- R3: When `evt_kind` is 2'b10 or 2'b11 (not a tracked kind), `match_o` is 1 after the next edge. This holds whatever the descriptor and configuration are, including when `req_valid` is 0.
- R4: For the tracked kinds (2'b00 queue insertion, 2'b01 queue occupancy), `req_valid` at 0 gives `match_o` = 0.
- R5: For tracked kinds, a `req_queue` different from `cfg_queue` gives `match_o` = 0.
- R6: When both `cfg_opc_a` and `cfg_opc_b` are 0, the opcode stage accepts every `req_opcode`, including 0.
- R7: A comparator with a non-zero value accepts the opcode equal to that value. A request passes the opcode stage if either non-zero comparator accepts it. A comparator at 0 never accepts, so opcode 0 fails when only one comparator is zero.
- R8: With `cfg_loc_en` and `cfg_rem_en` both set or both clear, the target check passes. With only `cfg_loc_en` set, `req_local` must be 1. With only `cfg_rem_en` set, `req_local` must be 0.
- R9: With `cfg_near_en` and `cfg_far_en` both set or both clear, the memory check passes. With only `cfg_near_en` set, `req_near` must be 1. With only `cfg_far_en` set, `req_near` must be 0.
- R10: With `cfg_nc_en` set, a tracked request passes only if `req_noncoh` is 1. With `cfg_nc_en` clear, `req_noncoh` has no effect.
- R11: With `cfg_isoc_en` set, a tracked request passes only if `req_isoc` is 1. With `cfg_isoc_en` clear, `req_isoc` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_opc_a | input | OPC_W | First opcode compare value, 0 = unused |
| cfg_opc_b | input | OPC_W | Second opcode compare value, 0 = unused |
| cfg_queue | input | QID_W | Queue a request must come from |
| cfg_loc_en | input | 1 | Accept local-target requests |
| cfg_rem_en | input | 1 | Accept remote-target requests |
| cfg_near_en | input | 1 | Accept near-memory-cacheable requests |
| cfg_far_en | input | 1 | Accept not-near-memory requests |
| cfg_nc_en | input | 1 | Require non-coherent flag |
| cfg_isoc_en | input | 1 | Require isochronous flag |
| evt_kind | input | 2 | 00 insertion, 01 occupancy, 1x other |
| req_valid | input | 1 | Descriptor valid |
| req_queue | input | QID_W | Queue identifier of the request |
| req_opcode | input | OPC_W | Request opcode |
| req_local | input | 1 | 1 = local target, 0 = remote |
| req_near | input | 1 | 1 = near-memory cacheable |
| req_noncoh | input | 1 | Non-coherent request |
| req_isoc | input | 1 | Isochronous request |
| match_o | output | 1 | Registered count qualifier |

## Verification
Every result of this block is due exactly one rising edge after the inputs that produce it are presented. The bench drives a new descriptor and configuration on the falling edge. It computes the expected bit from those values before the next rising edge, then compares `match_o` at the falling edge that follows. One extra check reads `match_o` between a drive and the next rising edge, to confirm that the old value is still held there. Directed cases cover each filter in isolation, and a long seeded random run mixes all of them.

// File: rtl/req_qual.sv
module req_qual #(
  parameter int OPC_W = 8,
  parameter int QID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] cfg_opc_a,
  input  logic [OPC_W-1:0] cfg_opc_b,
  input  logic [QID_W-1:0] cfg_queue,
  input  logic             cfg_loc_en,
  input  logic             cfg_rem_en,
  input  logic             cfg_near_en,
  input  logic             cfg_far_en,
  input  logic             cfg_nc_en,
  input  logic             cfg_isoc_en,
  input  logic [1:0]       evt_kind,
  input  logic             req_valid,
  input  logic [QID_W-1:0] req_queue,
  input  logic [OPC_W-1:0] req_opcode,
  input  logic             req_local,
  input  logic             req_near,
  input  logic             req_noncoh,
  input  logic             req_isoc,
  output logic             match_o
);

  logic a_on, b_on, opc_ok, q_ok, loc_ok, mem_ok, nc_ok, isoc_ok, tracked, next_match;

  assign a_on    = |cfg_opc_a;
  assign b_on    = |cfg_opc_b;
  assign opc_ok  = (!a_on && !b_on)
                 || (a_on && req_opcode == cfg_opc_a)
                 || (b_on && req_opcode == cfg_opc_b);
  assign q_ok    = req_queue == cfg_queue;
  assign loc_ok  = (cfg_loc_en == cfg_rem_en)
                 || (cfg_loc_en && req_local)
                 || (cfg_rem_en && !req_local);
  assign mem_ok  = (cfg_near_en == cfg_far_en)
                 || (cfg_near_en && req_near)
                 || (cfg_far_en && !req_near);
  assign nc_ok   = !cfg_nc_en || req_noncoh;
  assign isoc_ok = !cfg_isoc_en || req_isoc;
  assign tracked = !evt_kind[1];

  assign next_match = tracked
                    ? (req_valid && q_ok && opc_ok && loc_ok && mem_ok && nc_ok && isoc_ok)
                    : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) match_o <= 1'b0;
    else        match_o <= next_match;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !match_o);

  // R3
  untracked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_kind[1] |=> match_o);

  // R4
  invalid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_kind[1] && !req_valid) |=> !match_o);

  // R5
  queue_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_kind[1] && req_queue != cfg_queue) |=> !match_o);

  // R7
  opc_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_kind[1] && (cfg_opc_a != '0 || cfg_opc_b != '0)
     && req_opcode != cfg_opc_a && req_opcode != cfg_opc_b) |=> !match_o);

  // R10
  noncoh_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_kind[1] && cfg_nc_en && !req_noncoh) |=> !match_o);

  // R11
  isoc_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_kind[1] && cfg_isoc_en && !req_isoc) |=> !match_o);

endmodule

// File: tb/req_qual_test.sv
`timescale 1ns/1ps
module req_qual_test;
  localparam int OW = 8;
  localparam int QW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OW-1:0] cfg_opc_a = '0, cfg_opc_b = '0, req_opcode = '0;
  logic [QW-1:0] cfg_queue = '0, req_queue = '0;
  logic cfg_loc_en = 0, cfg_rem_en = 0, cfg_near_en = 0, cfg_far_en = 0;
  logic cfg_nc_en = 0, cfg_isoc_en = 0;
  logic [1:0] evt_kind = 2'b10;
  logic req_valid = 0, req_local = 0, req_near = 0, req_noncoh = 0, req_isoc = 0;
  logic match_o;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  req_qual #(.OPC_W(OW), .QID_W(QW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_opc_a(cfg_opc_a), .cfg_opc_b(cfg_opc_b), .cfg_queue(cfg_queue),
    .cfg_loc_en(cfg_loc_en), .cfg_rem_en(cfg_rem_en),
    .cfg_near_en(cfg_near_en), .cfg_far_en(cfg_far_en),
    .cfg_nc_en(cfg_nc_en), .cfg_isoc_en(cfg_isoc_en),
    .evt_kind(evt_kind), .req_valid(req_valid), .req_queue(req_queue),
    .req_opcode(req_opcode), .req_local(req_local), .req_near(req_near),
    .req_noncoh(req_noncoh), .req_isoc(req_isoc), .match_o(match_o)
  );

  function automatic logic model();
    logic opc, loc, mem;
    if (evt_kind[1]) return 1'b1;
    if (cfg_opc_a == 0 && cfg_opc_b == 0) opc = 1'b1;
    else opc = (cfg_opc_a != 0 && req_opcode == cfg_opc_a) ||
               (cfg_opc_b != 0 && req_opcode == cfg_opc_b);
    if (cfg_loc_en == cfg_rem_en) loc = 1'b1;
    else loc = cfg_loc_en ? req_local : !req_local;
    if (cfg_near_en == cfg_far_en) mem = 1'b1;
    else mem = cfg_near_en ? req_near : !req_near;
    return req_valid && (req_queue == cfg_queue) && opc && loc && mem &&
           (!cfg_nc_en || req_noncoh) && (!cfg_isoc_en || req_isoc);
  endfunction

  task automatic check(input string tag, input logic exp);
    checks++;
    if (match_o !== exp) begin
      fails++;
      $display("FAIL %s: match_o=%b expected=%b at %0t", tag, match_o, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic e;
    e = model();
    @(posedge clk);
    @(negedge clk);
    check(tag, e);
  endtask

  task automatic base();
    cfg_opc_a = '0; cfg_opc_b = '0; cfg_queue = 3'd2;
    cfg_loc_en = 0; cfg_rem_en = 0; cfg_near_en = 0; cfg_far_en = 0;
    cfg_nc_en = 0; cfg_isoc_en = 0;
    evt_kind = 2'b00; req_valid = 1; req_queue = 3'd2; req_opcode = 8'h11;
    req_local = 0; req_near = 0; req_noncoh = 0; req_isoc = 0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    // R1: inputs would pass, reset holds output low
    evt_kind = 2'b10;
    repeat (3) @(negedge clk);
    check("R1 during reset", 1'b0);
    rst_n = 1'b1;
    check("R1 at release", 1'b0);

    // R3 untracked kinds pass with invalid descriptor
    base(); req_valid = 0; evt_kind = 2'b10; step("R3 kind 10");
    evt_kind = 2'b11; cfg_nc_en = 1; req_queue = 3'd5; step("R3 kind 11");

    // R2 latency: value held until the edge
    base(); req_valid = 0; step("R4 invalid insertion");
    base(); evt_kind = 2'b01;
    #1 check("R2 held before edge", 1'b0);
    step("R2 after edge");

    base(); evt_kind = 2'b01; req_valid = 0; step("R4 invalid occupancy");
    base(); req_queue = 3'd3; step("R5 queue mismatch");
    base(); step("R5 queue match");

    // R6
    base(); req_opcode = 8'h00; step("R6 both zero opcode 0");
    base(); req_opcode = 8'hFF; step("R6 both zero opcode FF");
    // R7
    base(); cfg_opc_a = 8'h11; step("R7 A hit");
    base(); cfg_opc_b = 8'h11; step("R7 B hit");
    base(); cfg_opc_a = 8'h22; cfg_opc_b = 8'h11; step("R7 B hit A miss");
    base(); cfg_opc_a = 8'h22; cfg_opc_b = 8'h33; step("R7 both miss");
    base(); cfg_opc_b = 8'h05; req_opcode = 8'h00; step("R7 zero matcher no hit");

    // R8
    base(); cfg_loc_en = 1; req_local = 1; step("R8 local only hit");
    base(); cfg_loc_en = 1; req_local = 0; step("R8 local only miss");
    base(); cfg_rem_en = 1; req_local = 0; step("R8 remote only hit");
    base(); cfg_rem_en = 1; req_local = 1; step("R8 remote only miss");
    base(); cfg_loc_en = 1; cfg_rem_en = 1; req_local = 0; step("R8 both set");
    // R9
    base(); cfg_near_en = 1; req_near = 0; step("R9 near only miss");
    base(); cfg_far_en = 1; req_near = 0; step("R9 far only hit");
    base(); cfg_far_en = 1; req_near = 1; step("R9 far only miss");
    base(); cfg_near_en = 1; cfg_far_en = 1; req_near = 1; step("R9 both set");
    // R10
    base(); cfg_nc_en = 1; step("R10 missing flag");
    base(); cfg_nc_en = 1; req_noncoh = 1; step("R10 flag set");
    base(); req_noncoh = 1; step("R10 flag ignored");
    // R11
    base(); cfg_isoc_en = 1; step("R11 missing flag");
    base(); cfg_isoc_en = 1; req_isoc = 1; step("R11 flag set");
    base(); req_isoc = 1; step("R11 flag ignored");

    for (int i = 0; i < 4000; i++) begin
      cfg_opc_a = OW'($urandom % 4); cfg_opc_b = OW'($urandom % 4);
      req_opcode = OW'($urandom % 4);
      cfg_queue = QW'($urandom % 2); req_queue = QW'($urandom % 2);
      cfg_loc_en = 1'($urandom); cfg_rem_en = 1'($urandom);
      cfg_near_en = 1'($urandom); cfg_far_en = 1'($urandom);
      cfg_nc_en = ($urandom % 4) == 0; cfg_isoc_en = ($urandom % 4) == 0;
      evt_kind = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'($urandom % 2);
      req_valid = ($urandom % 8) != 0;
      req_local = 1'($urandom); req_near = 1'($urandom);
      req_noncoh = 1'($urandom); req_isoc = 1'($urandom);
      step("random mix R5 R6 R7 R8 R9 R10 R11");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule